// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Guard

This block sits next to a two-wire bus interface (target or controller) and observes already-synchronized copies of the clock and data lines. From the line activity it tracks whether a transfer is in progress: a falling data line while the clock is high opens a transfer, and a rising data line while the clock is high closes it. While a transfer is open, it counts how many system clock cycles the bus clock has been held low without interruption.

If the bus clock stays low longer than the SMBus limit of roughly 35 ms, the block emits a one-cycle reset pulse. The neighbouring interface logic uses this pulse to return to idle and release its line drivers so the bus can restart. The same event sets a sticky flag that software clears. The guard then treats the bus as free and waits for a fresh start condition. The limit check can be switched off for plain I2C operation, which has no bound on clock stretching.

The limit in cycles is computed as `CLK_KHZ * TIMEOUT_MS`. With the defaults (125 MHz and 35 ms) this is 4,375,000 cycles. A test can shrink it by overriding the two parameters.

Top module: `smb_lowtime_guard`

## Requirements
- R1: After reset, `busy_o`, `tmo_rst_o` and `tmo_flag_o` are all 0.
- R2: A start condition sets `busy_o` on the cycle after it is sampled. A start condition is `sda_i` going from 1 to 0 while `scl_i` is 1 on both samples.
- R3: A stop condition clears `busy_o`. A stop condition is `sda_i` going from 0 to 1 while `scl_i` is 1 on both samples.
- R4: While `busy_o` and `en_i` are both 1, `tmo_rst_o` rises after exactly LIMIT = `CLK_KHZ*TIMEOUT_MS` consecutive samples of `scl_i` = 0. It does not rise after LIMIT-1 such samples.
- R5: `tmo_rst_o` is high for exactly one cycle. `busy_o` is 0 in that same cycle.
- R6: Any sample of `scl_i` = 1 restarts the low-time count, so two low stretches that are each shorter than LIMIT never cause a timeout.
- R7: While `en_i` is 0, no timeout occurs, however long `scl_i` stays low.
- R8: While `busy_o` is 0, no timeout occurs, however long `scl_i` stays low.
- R9: `tmo_flag_o` is set together with the pulse and stays set until `clr_i` is 1 for a cycle. It then reads 0.
- R10: After a timeout, `busy_o` stays 0 and no further pulse occurs until a new start condition. After that start, the guard times out again as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| en_i | input | 1 | 1 = enforce the clock-low limit (SMBus), 0 = no limit (plain I2C) |
| clr_i | input | 1 | Clears the sticky timeout flag |
| tmo_rst_o | output | 1 | One-cycle reset pulse to the attached interface logic |
| busy_o | output | 1 | A transfer is in progress |
| tmo_flag_o | output | 1 | Sticky timeout status |

## Verification
The hardest case to reach is the exact boundary of the limit. The count depends on how many clock edges sample `scl_i` low, so the bench changes the lines only on falling clock edges. It walks a table of low-stretch lengths just below, at, and above a 20-cycle limit, with the check both enabled and disabled. A second hard case is the state after a timeout while the clock is still held low. The bench keeps `scl_i` low well past the pulse to show that no further pulse occurs. It then issues a new start to show the guard re-arms.

// File: rtl/smb_lowtime_guard.sv
module smb_lowtime_guard #(
  parameter int CLK_KHZ    = 125000,
  parameter int TIMEOUT_MS = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic en_i,
  input  logic clr_i,
  output logic tmo_rst_o,
  output logic busy_o,
  output logic tmo_flag_o
);

  localparam int LIMIT = CLK_KHZ * TIMEOUT_MS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic          scl_q, sda_q;
  logic [CW-1:0] low_cnt;
  logic          start_ev, stop_ev, hit;

  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
  assign hit      = busy_o & en_i & ~scl_i & (low_cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_o <= 1'b0;
    else if (hit)
      busy_o <= 1'b0;
    else if (start_ev)
      busy_o <= 1'b1;
    else if (stop_ev)
      busy_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (!busy_o || !en_i || scl_i || stop_ev || hit)
      low_cnt <= '0;
    else
      low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_rst_o  <= 1'b0;
      tmo_flag_o <= 1'b0;
    end else begin
      tmo_rst_o <= hit;
      if (hit)
        tmo_flag_o <= 1'b1;
      else if (clr_i)
        tmo_flag_o <= 1'b0;
    end
  end

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_rst_o |=> !tmo_rst_o);

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_rst_o |-> !busy_o);

  // R9
  flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_rst_o |-> tmo_flag_o);

  // R7
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !tmo_rst_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !tmo_rst_o);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && scl_i && scl_q && sda_q && !sda_i) |=> busy_o);

endmodule

// File: tb/tb_smb_lowtime_guard.sv
module tb_smb_lowtime_guard;
  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, en_i = 1'b1, clr_i = 1'b0;
  logic tmo_rst_o, busy_o, tmo_flag_o;
  int   errs = 0, checks = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  smb_lowtime_guard #(.CLK_KHZ(1), .TIMEOUT_MS(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .en_i(en_i),
    .clr_i(clr_i), .tmo_rst_o(tmo_rst_o), .busy_o(busy_o), .tmo_flag_o(tmo_flag_o));

  // {en, low length}
  localparam logic [8:0] VEC [9] = '{
    {1'b1, 8'd5}, {1'b1, 8'd19}, {1'b1, 8'd20}, {1'b1, 8'd21}, {1'b1, 8'd40},
    {1'b0, 8'd40}, {1'b0, 8'd19}, {1'b1, 8'd1}, {1'b1, 8'd60}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start();
    sda_i = 1'b1; scl_i = 1'b1; tick(2);
    sda_i = 1'b0; tick(2);
  endtask

  task automatic low_run(int len, output int pulses);
    pulses = 0;
    scl_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tmo_rst_o) pulses++;
    end
    scl_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (tmo_rst_o) pulses++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int p, exp;
    tick(3);
    chk("R1 busy", busy_o, 0);
    chk("R1 pulse", tmo_rst_o, 0);
    chk("R1 flag", tmo_flag_o, 0);
    rst_n = 1'b1;
    tick(2);

    foreach (VEC[k]) begin
      en_i = VEC[k][8];
      do_start();
      chk("R2 busy after start", busy_o, 1);
      low_run(int'(VEC[k][7:0]), p);
      exp = (en_i && VEC[k][7:0] >= LIM) ? 1 : 0;
      chk(en_i ? "R4/R5 pulse count" : "R7 pulse count", p, exp);
      chk("R5 busy after run", busy_o, exp ? 0 : 1);
      chk("R9 flag", tmo_flag_o, exp);
      sda_i = 1'b1; tick(2);
      chk("R3 busy after stop", busy_o, 0);
      clr_i = 1'b1; tick(1); clr_i = 1'b0;
      chk("R9 flag cleared", tmo_flag_o, 0);
    end
    en_i = 1'b1;

    // R6: two sub-limit stretches separated by one high sample
    do_start();
    scl_i = 1'b0; tick(15); scl_i = 1'b1; tick(1);
    low_run(15, p);
    chk("R6 no pulse", p, 0);
    chk("R6 busy", busy_o, 1);
    sda_i = 1'b1; tick(2);

    // R8: idle bus with clock held low
    chk("R8 idle", busy_o, 0);
    low_run(50, p);
    chk("R8 no pulse", p, 0);
    chk("R8 flag", tmo_flag_o, 0);

    // R10: hold low past timeout, then re-arm
    do_start();
    low_run(70, p);
    chk("R10 single pulse", p, 1);
    chk("R10 busy stays low", busy_o, 0);
    tick(10);
    chk("R9 flag holds", tmo_flag_o, 1);
    clr_i = 1'b1; tick(1); clr_i = 1'b0;
    chk("R9 flag clear", tmo_flag_o, 0);
    do_start();
    chk("R10 rearm busy", busy_o, 1);
    low_run(LIM, p);
    chk("R10 rearm pulse", p, 1);
    chk("R10 rearm flag", tmo_flag_o, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule